// File: doc/BRIEF.md
# Test Access Port Controller with User Scan Hooks

This block is the serial test port of a chip: a 16-state controller advanced by the test mode select line on each rising test clock, a 3-bit instruction register, a one-bit pass-through register, and the multiplexer that chooses which register drives the serial output. The output and its enable update on the falling test clock.

Besides the external boundary chain, which is reached through state decodes and a single return input, two user instructions let logic elsewhere on the chip hang its own scan registers off the port. Each user instruction raises its own select line and routes a user-supplied serial return to the output. A gated data-register clock lets that user logic clock its register only while it is captured or shifted. An active-low idle strobe is the NAND of the test clock and the Run-Test/Idle state.

Top module: `jtag_user_tap`

## Requirements
- R1: While `tap_rst` is high at a rising `tck`, the controller enters Test-Logic-Reset and the instruction becomes bypass (code 111). After reset `tdo_en`, `usr_sel1`, `usr_sel2`, `bnd_sel` and `bnd_extest` are all low.
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state, and the instruction is then reloaded with bypass (111).
- R3: Capture-IR loads 001 into the instruction shift stage. Shift-IR moves it toward `tdo` least significant bit first, so the first three bits seen on `tdo` are 1, 0, 0.
- R4: Under bypass, Capture-DR clears the pass-through bit. Each Shift-DR bit then appears on `tdo` one `tck` later, with 0 as the first bit out.
- R5: Instruction codes decode as 000 boundary test (EXTEST), 001 boundary sample, 010 user one, 011 user two. Every other code selects bypass. At most one of `usr_sel1`, `usr_sel2`, `bnd_sel` is high.
- R6: With code 010 loaded, `usr_sel1` is high and `tdo` in Shift-DR follows `usr_tdo1`.
- R7: With code 011 loaded, `usr_sel2` is high and `tdo` in Shift-DR follows `usr_tdo2`.
- R8: `usr_drck` pulses with `tck` only for rising edges taken in Capture-DR or Shift-DR while a user instruction is loaded: an n-bit user scan gives n+1 pulses, and a bypass scan gives none.
- R9: `usr_idle_n` is low exactly while `tck` is high and the controller is in Run-Test/Idle.
- R10: `tdo` and `tdo_en` change only on falling `tck`. `tdo_en` is high exactly during Shift-IR and Shift-DR.
- R11: Codes 000 and 001 raise `bnd_sel` and take `tdo` in Shift-DR from `bnd_tdo`. `bnd_extest` is high only for 000. `bnd_capture`, `bnd_shift` and `bnd_update` mark the DR capture, shift and update states only while `bnd_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high port reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| bnd_tdo | input | 1 | Serial return from the external boundary chain |
| bnd_sel | output | 1 | Boundary chain is the selected data register |
| bnd_extest | output | 1 | Boundary test mode: chain drives pins |
| bnd_capture | output | 1 | Boundary chain capture state |
| bnd_shift | output | 1 | Boundary chain shift state |
| bnd_update | output | 1 | Boundary chain update state |
| usr_sel1 | output | 1 | User instruction one is loaded |
| usr_sel2 | output | 1 | User instruction two is loaded |
| usr_tdo1 | input | 1 | Serial return of user register one |
| usr_tdo2 | input | 1 | Serial return of user register two |
| usr_drck | output | 1 | Gated data-register clock for user logic |
| usr_idle_n | output | 1 | NAND of tck and Run-Test/Idle |

## Verification
The assertions check on every rising edge that reset and the Test-Logic-Reset state leave bypass selected, that IR capture loads 001, that the pass-through bit holds the previous `tdi` during Shift-DR, that the selects are mutually exclusive, and that `tdo_en` matches the shift states. The bench scenarios alone show the serial streams on `tdo` for each instruction, the routing of the user and boundary returns, the count of `usr_drck` pulses per scan, and the phase of `usr_idle_n` within the clock period.

// File: rtl/jtag_user_tap_pkg.sv
package jtag_user_tap_pkg;

    parameter int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST = IR_W'(0);
    localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(1);
    localparam logic [IR_W-1:0] OP_USER1  = IR_W'(2);
    localparam logic [IR_W-1:0] OP_USER2  = IR_W'(3);
    localparam logic [IR_W-1:0] OP_BYPASS = {IR_W{1'b1}};
    localparam logic [IR_W-1:0] IR_CAPT   = IR_W'(1);

    typedef enum logic [3:0] {
        TS_TLR, TS_RTI,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic [2:0] {
        PATH_BYPASS, PATH_EXTEST, PATH_SAMPLE, PATH_USER1, PATH_USER2
    } path_t;

    typedef struct packed {
        logic tlr;
        logic rti;
        logic cap_dr;
        logic shf_dr;
        logic upd_dr;
        logic cap_ir;
        logic shf_ir;
        logic upd_ir;
    } tap_ctl_t;

    function automatic tap_state_t next_state(input tap_state_t s, input logic tms);
        case (s)
            TS_TLR:    return tms ? TS_TLR    : TS_RTI;
            TS_RTI:    return tms ? TS_SEL_DR : TS_RTI;
            TS_SEL_DR: return tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: return tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: return tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: return tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: return tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: return tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: return tms ? TS_SEL_DR : TS_RTI;
            TS_SEL_IR: return tms ? TS_TLR    : TS_CAP_IR;
            TS_CAP_IR: return tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: return tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: return tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: return tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: return tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: return tms ? TS_SEL_DR : TS_RTI;
            default:   return TS_TLR;
        endcase
    endfunction

    function automatic tap_ctl_t ctl_decode(input tap_state_t s);
        tap_ctl_t c;
        c.tlr    = (s == TS_TLR);
        c.rti    = (s == TS_RTI);
        c.cap_dr = (s == TS_CAP_DR);
        c.shf_dr = (s == TS_SHF_DR);
        c.upd_dr = (s == TS_UPD_DR);
        c.cap_ir = (s == TS_CAP_IR);
        c.shf_ir = (s == TS_SHF_IR);
        c.upd_ir = (s == TS_UPD_IR);
        return c;
    endfunction

    function automatic path_t path_decode(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST: return PATH_EXTEST;
            OP_SAMPLE: return PATH_SAMPLE;
            OP_USER1:  return PATH_USER1;
            OP_USER2:  return PATH_USER2;
            default:   return PATH_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_user_tap_pkg::*;
(
    input  logic       tck,
    input  logic       tap_rst,
    input  logic       tms,
    output tap_state_t state,
    output tap_ctl_t   ctl
);
    tap_state_t state_q;

    always_ff @(posedge tck) begin
        if (tap_rst) state_q <= TS_TLR;
        else         state_q <= next_state(state_q, tms);
    end

    assign state = state_q;
    assign ctl   = ctl_decode(state_q);
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_user_tap_pkg::*;
(
    input  logic            tck,
    input  logic            tap_rst,
    input  logic            tdi,
    input  tap_ctl_t        ctl,
    output logic [IR_W-1:0] ir_sr,
    output path_t           path
);
    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] op_q;

    always_ff @(posedge tck) begin
        if (tap_rst) begin
            sr_q <= IR_CAPT;
            op_q <= OP_BYPASS;
        end else begin
            if (ctl.cap_ir)      sr_q <= IR_CAPT;
            else if (ctl.shf_ir) sr_q <= {tdi, sr_q[IR_W-1:1]};
            if (ctl.tlr)         op_q <= OP_BYPASS;
            else if (ctl.upd_ir) op_q <= sr_q;
        end
    end

    assign ir_sr = sr_q;
    assign path  = path_decode(op_q);
endmodule

// File: rtl/tap_bypass.sv
module tap_bypass
    import jtag_user_tap_pkg::*;
(
    input  logic     tck,
    input  logic     tap_rst,
    input  logic     tdi,
    input  tap_ctl_t ctl,
    output logic     byp_q
);
    logic bit_q;

    always_ff @(posedge tck) begin
        if (tap_rst)         bit_q <= 1'b0;
        else if (ctl.cap_dr) bit_q <= 1'b0;
        else if (ctl.shf_dr) bit_q <= tdi;
    end

    assign byp_q = bit_q;
endmodule

// File: rtl/tap_out.sv
module tap_out
    import jtag_user_tap_pkg::*;
(
    input  logic     tck,
    input  logic     tap_rst,
    input  tap_ctl_t ctl,
    input  path_t    path,
    input  logic     ir_lsb,
    input  logic     byp_q,
    input  logic     bnd_tdo,
    input  logic     usr_tdo1,
    input  logic     usr_tdo2,
    output logic     tdo,
    output logic     tdo_en,
    output logic     usr_drck,
    output logic     usr_idle_n
);
    logic tdo_d;
    logic user_path;
    logic tdo_q;
    logic en_q;
    logic drck_en_q;

    assign user_path = (path == PATH_USER1) || (path == PATH_USER2);

    always_comb begin
        if (ctl.shf_ir) begin
            tdo_d = ir_lsb;
        end else begin
            case (path)
                PATH_EXTEST, PATH_SAMPLE: tdo_d = bnd_tdo;
                PATH_USER1:               tdo_d = usr_tdo1;
                PATH_USER2:               tdo_d = usr_tdo2;
                default:                  tdo_d = byp_q;
            endcase
        end
    end

    // Falling-edge stage: output timing and a glitch-free clock gate enable.
    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo_q     <= 1'b0;
            en_q      <= 1'b0;
            drck_en_q <= 1'b0;
        end else begin
            tdo_q     <= tdo_d;
            en_q      <= ctl.shf_ir | ctl.shf_dr;
            drck_en_q <= user_path & (ctl.cap_dr | ctl.shf_dr);
        end
    end

    assign tdo        = tdo_q;
    assign tdo_en     = en_q;
    assign usr_drck   = tck & drck_en_q;
    assign usr_idle_n = ~(tck & ctl.rti);
endmodule

// File: rtl/jtag_user_tap.sv
module jtag_user_tap
    import jtag_user_tap_pkg::*;
(
    input  logic tck,
    input  logic tap_rst,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic bnd_tdo,
    output logic bnd_sel,
    output logic bnd_extest,
    output logic bnd_capture,
    output logic bnd_shift,
    output logic bnd_update,
    output logic usr_sel1,
    output logic usr_sel2,
    input  logic usr_tdo1,
    input  logic usr_tdo2,
    output logic usr_drck,
    output logic usr_idle_n
);
    tap_state_t      state;
    tap_ctl_t        ctl;
    logic [IR_W-1:0] ir_sr;
    path_t           path;
    logic            byp_q;

    tap_fsm u_fsm (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .state(state), .ctl(ctl)
    );

    tap_ir u_ir (
        .tck(tck), .tap_rst(tap_rst), .tdi(tdi), .ctl(ctl), .ir_sr(ir_sr), .path(path)
    );

    tap_bypass u_byp (
        .tck(tck), .tap_rst(tap_rst), .tdi(tdi), .ctl(ctl), .byp_q(byp_q)
    );

    tap_out u_out (
        .tck(tck), .tap_rst(tap_rst), .ctl(ctl), .path(path), .ir_lsb(ir_sr[0]),
        .byp_q(byp_q), .bnd_tdo(bnd_tdo), .usr_tdo1(usr_tdo1), .usr_tdo2(usr_tdo2),
        .tdo(tdo), .tdo_en(tdo_en), .usr_drck(usr_drck), .usr_idle_n(usr_idle_n)
    );

    assign bnd_sel     = (path == PATH_EXTEST) || (path == PATH_SAMPLE);
    assign bnd_extest  = (path == PATH_EXTEST);
    assign bnd_capture = bnd_sel & ctl.cap_dr;
    assign bnd_shift   = bnd_sel & ctl.shf_dr;
    assign bnd_update  = bnd_sel & ctl.upd_dr;
    assign usr_sel1    = (path == PATH_USER1);
    assign usr_sel2    = (path == PATH_USER2);
endmodule

// File: rtl/tap_user_chk.sv
module tap_user_chk
    import jtag_user_tap_pkg::*;
(
    input logic            tck,
    input logic            tap_rst,
    input logic            tdi,
    input tap_state_t      state,
    input path_t           path,
    input logic [IR_W-1:0] ir_sr,
    input logic            byp_q,
    input logic            usr_sel1,
    input logic            usr_sel2,
    input logic            bnd_sel,
    input logic            tdo_en
);
    AST_TLR_BYPASS: assert property (@(posedge tck) disable iff (tap_rst)
        (state == TS_TLR) |=> (path == PATH_BYPASS)); // R2

    AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (tap_rst)
        (state == TS_CAP_IR) |=> (ir_sr == IR_CAPT)); // R3

    AST_BYPASS_DELAY: assert property (@(posedge tck) disable iff (tap_rst)
        (state == TS_SHF_DR) |=> (byp_q == $past(tdi))); // R4

    AST_SEL_ONEHOT: assert property (@(posedge tck) disable iff (tap_rst)
        $onehot0({usr_sel1, usr_sel2, bnd_sel})); // R5

    AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (tap_rst)
        tdo_en == ((state == TS_SHF_DR) || (state == TS_SHF_IR))); // R10
endmodule

bind jtag_user_tap tap_user_chk u_chk (
    .tck(tck), .tap_rst(tap_rst), .tdi(tdi), .state(state), .path(path),
    .ir_sr(ir_sr), .byp_q(byp_q), .usr_sel1(usr_sel1), .usr_sel2(usr_sel2),
    .bnd_sel(bnd_sel), .tdo_en(tdo_en)
);

// File: tb/jtag_user_tap_bench.sv
module jtag_user_tap_bench;
    logic tck = 1'b0;
    logic tap_rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic bnd_tdo = 1'b0;
    logic usr_tdo1 = 1'b0;
    logic usr_tdo2 = 1'b0;
    logic tdo, tdo_en, bnd_sel, bnd_extest, bnd_capture, bnd_shift, bnd_update;
    logic usr_sel1, usr_sel2, usr_drck, usr_idle_n;

    int n_cmp = 0;
    int n_bad = 0;
    int drck_cnt = 0;
    bit sample_now = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic  v;
        string req;
    } exp_t;
    exp_t sb[$];

    always #2 tck = ~tck;

    jtag_user_tap u_jtag_user_tap (
        .tck(tck), .tap_rst(tap_rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .bnd_tdo(bnd_tdo), .bnd_sel(bnd_sel), .bnd_extest(bnd_extest),
        .bnd_capture(bnd_capture), .bnd_shift(bnd_shift), .bnd_update(bnd_update),
        .usr_sel1(usr_sel1), .usr_sel2(usr_sel2), .usr_tdo1(usr_tdo1), .usr_tdo2(usr_tdo2),
        .usr_drck(usr_drck), .usr_idle_n(usr_idle_n)
    );

    always @(posedge usr_drck) drck_cnt = drck_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares tdo in each shift cycle against the scoreboard.
    always @(negedge tck) begin
        #1;
        if (sample_now) begin
            if (sb.size() == 0) begin
                check(1'b0, "scoreboard underflow", 0, 1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(tdo === e.v, e.req, int'(tdo), int'(e.v));
                check(tdo_en === 1'b1, "R10 tdo_en in shift", int'(tdo_en), 1);
            end
        end
    end

    task automatic step(input logic t);
        @(negedge tck);
        sample_now = 1'b0;
        tms = t;
    endtask

    task automatic shift_bits(input int n, input logic [31:0] din,
                              input logic [31:0] expv, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge tck);
            tdi = din[i];
            tms = (i == n - 1);
            sb.push_back('{v: expv[i], req: req});
            sample_now = 1'b1;
        end
        step(1'b1);   // exit1 -> update
        step(1'b0);   // update -> idle
    endtask

    task automatic load_ir(input logic [2:0] code);
        step(1'b1); step(1'b1); step(1'b0); step(1'b0);
        shift_bits(3, {29'd0, code}, 32'b001, "R3 IR capture stream");
        @(negedge tck);
        #1;
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din,
                           input logic [31:0] expv, input string req, output logic cap_seen);
        step(1'b1); step(1'b0);
        @(posedge tck);
        #1;
        cap_seen = bnd_capture;
        step(1'b0);
        shift_bits(n, din, expv, req);
        @(negedge tck);
        #1;
    endtask

    initial begin
        logic cap;
        logic [31:0] din;
        repeat (3) @(negedge tck);
        tap_rst = 1'b0;
        #1;
        check(tdo_en === 1'b0,     "R1 tdo_en after reset", int'(tdo_en), 0);
        check(usr_sel1 === 1'b0,   "R1 usr_sel1 after reset", int'(usr_sel1), 0);
        check(usr_sel2 === 1'b0,   "R1 usr_sel2 after reset", int'(usr_sel2), 0);
        check(bnd_sel === 1'b0,    "R1 bnd_sel after reset", int'(bnd_sel), 0);
        check(bnd_extest === 1'b0, "R1 bnd_extest after reset", int'(bnd_extest), 0);
        check(usr_idle_n === 1'b1, "R9 idle_n outside idle", int'(usr_idle_n), 1);
        step(1'b0);   // TLR -> RTI
        @(negedge tck);

        // R4: bypass after reset, one-cycle delay, leading 0
        din = 32'h0000_00B5;
        drck_cnt = 0;
        scan_dr(8, din, {din[30:0], 1'b0}, "R4 bypass stream", cap);
        check(drck_cnt == 0, "R8 no drck under bypass", drck_cnt, 0);
        check(cap === 1'b0, "R11 no boundary capture under bypass", int'(cap), 0);

        // R9: idle strobe phases while parked in Run-Test/Idle
        tms = 1'b0;
        @(posedge tck); #1;
        check(usr_idle_n === 1'b0, "R9 idle_n low with tck high in idle", int'(usr_idle_n), 0);
        @(negedge tck); #1;
        check(usr_idle_n === 1'b1, "R9 idle_n high with tck low", int'(usr_idle_n), 1);
        check(tdo_en === 1'b0, "R10 tdo_en low in idle", int'(tdo_en), 0);

        // R6: user one
        load_ir(3'b010);
        check(usr_sel1 === 1'b1, "R6 usr_sel1 with 010", int'(usr_sel1), 1);
        check(usr_sel2 === 1'b0, "R6 usr_sel2 with 010", int'(usr_sel2), 0);
        usr_tdo1 = 1'b1; usr_tdo2 = 1'b0;
        drck_cnt = 0;
        scan_dr(4, 32'h5, 32'hF, "R6 user one return", cap);
        check(drck_cnt == 5, "R8 drck pulses for 4-bit user scan", drck_cnt, 5);

        // R2: five TMS-high clocks restore bypass
        repeat (5) step(1'b1);
        step(1'b0);
        @(negedge tck); #1;
        check(usr_sel1 === 1'b0, "R2 usr_sel1 cleared by TMS reset", int'(usr_sel1), 0);
        din = 32'h0000_0006;
        scan_dr(4, din, {din[30:0], 1'b0}, "R2 bypass after TMS reset", cap);

        // R7: user two
        load_ir(3'b011);
        check(usr_sel2 === 1'b1, "R7 usr_sel2 with 011", int'(usr_sel2), 1);
        usr_tdo1 = 1'b0; usr_tdo2 = 1'b1;
        drck_cnt = 0;
        scan_dr(6, 32'h0, 32'h3F, "R7 user two return", cap);
        check(drck_cnt == 7, "R8 drck pulses for 6-bit user scan", drck_cnt, 7);
        usr_tdo2 = 1'b0;

        // R5: undefined code falls back to bypass
        load_ir(3'b101);
        check({usr_sel1, usr_sel2, bnd_sel} === 3'b000, "R5 no select for 101",
              int'({usr_sel1, usr_sel2, bnd_sel}), 0);
        din = 32'h0000_0009;
        scan_dr(5, din, {din[30:0], 1'b0}, "R5 bypass for undefined code", cap);

        // R11: boundary test and sample
        load_ir(3'b000);
        check(bnd_extest === 1'b1, "R11 bnd_extest with 000", int'(bnd_extest), 1);
        check(bnd_sel === 1'b1, "R11 bnd_sel with 000", int'(bnd_sel), 1);
        bnd_tdo = 1'b1;
        scan_dr(4, 32'h0, 32'hF, "R11 boundary return under test", cap);
        check(cap === 1'b1, "R11 bnd_capture in capture-DR", int'(cap), 1);
        load_ir(3'b001);
        check(bnd_extest === 1'b0, "R11 bnd_extest with 001", int'(bnd_extest), 0);
        check(bnd_sel === 1'b1, "R11 bnd_sel with 001", int'(bnd_sel), 1);
        bnd_tdo = 1'b0;
        scan_dr(4, 32'hF, 32'h0, "R11 boundary return under sample", cap);

        // R1: port reset from a non-bypass instruction
        tap_rst = 1'b1;
        repeat (2) @(negedge tck);
        tap_rst = 1'b0;
        #1;
        check(bnd_sel === 1'b0, "R1 bnd_sel cleared by reset", int'(bnd_sel), 0);

        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule